// File: doc/BRIEF.md
# Two-Pass 8x8 Forward Integer Transform

This block turns an 8x8 block of pixel residuals into 8x8 transform coefficients. It uses the integer approximation of the discrete cosine transform that block-based video encoders rely on. A caller supplies one row at a time: eight source pixels and the eight prediction pixels that go with them. The block subtracts them to form the residual and runs a one-dimensional 8-point transform on the row. The first-pass results are stored column-wise in an internal 8x8 buffer, so the stored matrix is the transpose of the first-pass output.

The one-dimensional transform is a butterfly. It adds and subtracts mirrored sample pairs, applies fixed integer weights to the sums for the even coefficients and to the differences for the odd coefficients, then adds half an LSB and shifts right arithmetically. After the eighth row has been taken, the block stops accepting rows. It runs the same butterfly over the eight buffered vectors with a larger shift and presents one column of the final coefficient matrix per cycle.

Top module: `dct8_2d`

## Requirements
- R1: While reset is held and on the first cycle after it, `outValid` is 0 and `inReady` is 1.
- R2: The residual of lane n is `srcPix` lane n minus `predPix` lane n, with both pixels taken as unsigned. Lane n occupies bits [n*PIX_W +: PIX_W].
- R3: The even coefficients follow the basis rows 0: (64 64 64 64 64 64 64 64), 2: (83 36 −36 −83 −83 −36 36 83), 4: (64 −64 −64 64 64 −64 −64 64) and 6: (36 −83 83 −36 −36 83 −83 36), applied to the eight input samples in lane order.
- R4: The odd coefficients follow the basis rows 1: (89 75 50 18 −18 −50 −75 −89), 3: (75 −18 −89 −50 50 89 18 −75), 5: (50 −89 18 75 −75 −18 89 −50) and 7: (18 −50 75 −89 89 −75 50 −18).
- R5: Each weighted sum gets 2^(shift−1) added and is then shifted right arithmetically. The shift is 2 in the first pass and 9 in the second for 8-bit pixels, so negative results round toward minus infinity after the offset.
- R6: First-pass output k of input row i is stored at buffer position (k, i). Second-pass step j transforms buffer row j, and `outCoef` lane k (bits [k*16 +: 16]) then carries final coefficient (k, j), vertical frequency k and horizontal frequency j.
- R7: A row is taken on a rising edge where `inValid` and `inReady` are both 1. Rows may arrive with idle cycles between them.
- R8: On the cycle after the eighth row is taken, `inReady` drops. It stays low for exactly eight cycles while the second pass runs, then rises.
- R9: `outValid` is high for exactly eight consecutive cycles per block, with `outIdx` counting 0 to 7. The first result appears two cycles after the eighth row is taken.
- R10: Rows offered while `inReady` is low are dropped: neither the current block's results nor the next block's results change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A row is offered |
| srcPix | input | 8*PIX_W | Eight source pixels, lane n at [n*PIX_W +: PIX_W] |
| predPix | input | 8*PIX_W | Eight prediction pixels, same lane layout |
| inReady | output | 1 | Block can take a row this cycle |
| outValid | output | 1 | `outCoef` holds a result column |
| outIdx | output | 3 | Column index j of the result |
| outCoef | output | 8*16 | Eight signed coefficients, lane k at [k*16 +: 16] |

## Verification
The bench targets negative residuals. There an arithmetic shift is needed: a logical shift, or a subtraction with the wrong operand order or width, produces large positive garbage or sign-flipped coefficients. Checkerboard and ramp inputs excite each odd basis row separately, so a swapped weight or a mis-mirrored pair shows up as a wrong value in a single lane. The bench compares full matrices from non-symmetric inputs, so an untransposed buffer write returns coefficients in swapped positions. It also feeds rows with gaps between them and offers junk rows during the second pass. A control path that counts `inValid` instead of accepted rows, or that writes during the drain, would corrupt the running block or the next one.

// File: rtl/dct8_pkg.sv
package dct8_pkg;
  localparam int LANES  = 8;
  localparam int COEF_W = 16;
  localparam int ACC_W  = 32;
  localparam int IDX_W  = $clog2(LANES);

  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrCol;
    logic             rdEn;
    logic [IDX_W-1:0] rdRow;
  } dct_ctl_t;

  function automatic coef_t satCoef(acc_t v);
    if (v > acc_t'(32767))       return coef_t'(16'sh7fff);
    else if (v < acc_t'(-32768)) return coef_t'(16'sh8000);
    else                         return coef_t'(v);
  endfunction
endpackage

// File: rtl/dct8_bfly.sv
module dct8_bfly
  import dct8_pkg::*;
(
  input  coef_t [LANES-1:0] vecIn,
  input  logic  [4:0]       shiftAmt,
  output acc_t  [LANES-1:0] coefOut
);
  acc_t [3:0] pairSum;
  acc_t [3:0] pairDif;
  acc_t [LANES-1:0] weighted;
  acc_t roundTerm;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      pairSum[k] = acc_t'(vecIn[k]) + acc_t'(vecIn[LANES-1-k]);
      pairDif[k] = acc_t'(vecIn[k]) - acc_t'(vecIn[LANES-1-k]);
    end
    weighted[0] = 64 * (pairSum[0] + pairSum[1] + pairSum[2] + pairSum[3]);
    weighted[4] = 64 * (pairSum[0] - pairSum[1] - pairSum[2] + pairSum[3]);
    weighted[2] = 83 * pairSum[0] + 36 * pairSum[1] - 36 * pairSum[2] - 83 * pairSum[3];
    weighted[6] = 36 * pairSum[0] - 83 * pairSum[1] + 83 * pairSum[2] - 36 * pairSum[3];
    weighted[1] = 89 * pairDif[0] + 75 * pairDif[1] + 50 * pairDif[2] + 18 * pairDif[3];
    weighted[3] = 75 * pairDif[0] - 18 * pairDif[1] - 89 * pairDif[2] - 50 * pairDif[3];
    weighted[5] = 50 * pairDif[0] - 89 * pairDif[1] + 18 * pairDif[2] + 75 * pairDif[3];
    weighted[7] = 18 * pairDif[0] - 50 * pairDif[1] + 75 * pairDif[2] - 89 * pairDif[3];
    roundTerm = acc_t'(1) << (shiftAmt - 5'd1);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_round
    assign coefOut[g] = (weighted[g] + roundTerm) >>> shiftAmt;
  end
endmodule

// File: rtl/dct8_ctrl.sv
module dct8_ctrl
  import dct8_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  output logic     inReady,
  output dct_ctl_t ctl
);
  typedef enum logic {ST_LOAD, ST_DRAIN} state_t;
  state_t           state;
  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_LOAD;
      cnt   <= '0;
    end else begin
      case (state)
        ST_LOAD: if (inValid) begin
          cnt <= cnt + 1'b1;
          if (cnt == IDX_W'(LANES - 1)) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          cnt <= cnt + 1'b1;
          if (cnt == IDX_W'(LANES - 1)) state <= ST_LOAD;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  always_comb begin
    inReady   = (state == ST_LOAD);
    ctl.wrEn  = (state == ST_LOAD) && inValid;
    ctl.wrCol = cnt;
    ctl.rdEn  = (state == ST_DRAIN);
    ctl.rdRow = cnt;
  end

  AST_DRAIN_AFTER_EIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrEn && cnt == IDX_W'(LANES - 1)) |=> (ctl.rdEn && ctl.rdRow == '0)); // R8
  AST_DRAIN_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdEn && cnt == IDX_W'(LANES - 1)) |=> (!ctl.rdEn && inReady)); // R8
endmodule

// File: rtl/dct8_datapath.sv
module dct8_datapath
  import dct8_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int SHIFT1 = 2,
  parameter int SHIFT2 = 9
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dct_ctl_t               ctl,
  input  logic [LANES*PIX_W-1:0] srcPix,
  input  logic [LANES*PIX_W-1:0] predPix,
  output logic                   outValid,
  output logic [IDX_W-1:0]       outIdx,
  output coef_t [LANES-1:0]      outCoef
);
  coef_t [LANES-1:0][LANES-1:0] tbuf;
  coef_t [LANES-1:0]            resid;
  coef_t [LANES-1:0]            bflyIn;
  acc_t  [LANES-1:0]            bflyOut;
  logic  [4:0]                  shiftSel;

  for (genvar n = 0; n < LANES; n++) begin : g_resid
    logic signed [PIX_W:0] diff;
    assign diff     = $signed({1'b0, srcPix[n*PIX_W +: PIX_W]})
                    - $signed({1'b0, predPix[n*PIX_W +: PIX_W]});
    assign resid[n] = coef_t'(diff);
  end

  assign bflyIn   = ctl.rdEn ? tbuf[ctl.rdRow] : resid;
  assign shiftSel = ctl.rdEn ? 5'(SHIFT2) : 5'(SHIFT1);

  dct8_bfly u_bfly (
    .vecIn   (bflyIn),
    .shiftAmt(shiftSel),
    .coefOut (bflyOut)
  );

  always_ff @(posedge clk) begin
    if (ctl.wrEn) begin
      for (int k = 0; k < LANES; k++) tbuf[k][ctl.wrCol] <= satCoef(bflyOut[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outIdx   <= '0;
      outCoef  <= '0;
    end else begin
      outValid <= ctl.rdEn;
      if (ctl.rdEn) begin
        outIdx <= ctl.rdRow;
        for (int k = 0; k < LANES; k++) outCoef[k] <= satCoef(bflyOut[k]);
      end
    end
  end

  AST_IDX_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (outIdx == '0)); // R9
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outIdx != IDX_W'(LANES - 1)) |=> (outValid && outIdx == $past(outIdx) + 1'b1)); // R9
endmodule

// File: rtl/dct8_2d.sv
module dct8_2d
  import dct8_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic [8*PIX_W-1:0]     srcPix,
  input  logic [8*PIX_W-1:0]     predPix,
  output logic                   inReady,
  output logic                   outValid,
  output logic [2:0]             outIdx,
  output logic [8*16-1:0]        outCoef
);
  localparam int LOG2N  = 3;
  localparam int SHIFT1 = LOG2N + PIX_W - 9;
  localparam int SHIFT2 = LOG2N + 6;

  dct_ctl_t         ctl;
  coef_t [LANES-1:0] coefArr;

  dct8_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inReady(inReady),
    .ctl    (ctl)
  );

  dct8_datapath #(
    .PIX_W (PIX_W),
    .SHIFT1(SHIFT1),
    .SHIFT2(SHIFT2)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .srcPix  (srcPix),
    .predPix (predPix),
    .outValid(outValid),
    .outIdx  (outIdx),
    .outCoef (coefArr)
  );

  assign outCoef = coefArr;

  AST_BUSY_WHILE_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outIdx != 3'd7) |-> !inReady); // R10
endmodule

// File: tb/dct8_2d_bench.sv
module dct8_2d_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [63:0]  srcPix = '0;
  logic [63:0]  predPix = '0;
  logic         inReady;
  logic         outValid;
  logic [2:0]   outIdx;
  logic [127:0] outCoef;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  int seed = 32'h1234_5678;

  int srcA [8][8];
  int predA[8][8];
  int expY [8][8];

  dct8_2d u_dct8_2d (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcPix(srcPix), .predPix(predPix),
    .inReady(inReady), .outValid(outValid), .outIdx(outIdx), .outCoef(outCoef)
  );

  always #10 clk = ~clk;

  function automatic int basis(int k, int n);
    int t[8][8] = '{
      '{64, 64, 64, 64, 64, 64, 64, 64},
      '{89, 75, 50, 18, -18, -50, -75, -89},
      '{83, 36, -36, -83, -83, -36, 36, 83},
      '{75, -18, -89, -50, 50, 89, 18, -75},
      '{64, -64, -64, 64, 64, -64, -64, 64},
      '{50, -89, 18, 75, -75, -18, 89, -50},
      '{36, -83, 83, -36, -36, 83, -83, 36},
      '{18, -50, 75, -89, 89, -75, 50, -18}};
    return t[k][n];
  endfunction

  function automatic int rnd(int acc, int sh);
    int v;
    v = (acc + (1 << (sh - 1))) >>> sh;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  function automatic int nextRand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 255;
  endfunction

  task automatic computeExpected();
    int tmp[8][8];
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 8; k++) begin
        int acc = 0;
        for (int n = 0; n < 8; n++) acc += basis(k, n) * (srcA[i][n] - predA[i][n]);
        tmp[k][i] = rnd(acc, 2);
      end
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 8; k++) begin
        int acc = 0;
        for (int n = 0; n < 8; n++) acc += basis(k, n) * tmp[j][n];
        expY[k][j] = rnd(acc, 9);
      end
  endtask

  task automatic check(bit ok, string req, int act, int expv, string what);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Feeds srcA/predA, optionally with idle gaps and junk during the drain, then checks all outputs.
  task automatic runBlock(string tag, bit gaps, bit junk);
    computeExpected();
    for (int i = 0; i < 8; i++) begin
      if (gaps && (i % 3 == 1)) begin
        inValid = 1'b0;
        @(negedge clk);
        check(outValid == 1'b0, "R7", outValid, 0, {tag, " idle cycle outValid"});
      end
      inValid = 1'b1;
      for (int n = 0; n < 8; n++) begin
        srcPix[n*8 +: 8]  = 8'(srcA[i][n]);
        predPix[n*8 +: 8] = 8'(predA[i][n]);
      end
      @(negedge clk);
    end
    inValid = junk;
    if (junk) begin srcPix = 64'hffff_ffff_ffff_ffff; predPix = '0; end
    check(inReady == 1'b0, "R8", inReady, 0, {tag, " ready after eighth row"});
    check(outValid == 1'b0, "R9", outValid, 0, {tag, " no result one cycle after"});
    @(negedge clk);
    for (int j = 0; j < 8; j++) begin
      if (junk) begin srcPix = {8{8'(nextRand())}}; predPix = {8{8'(nextRand())}}; end
      check(outValid == 1'b1, "R9", outValid, 1, {tag, " outValid"});
      check(outIdx == 3'(j), "R9", outIdx, j, {tag, " outIdx"});
      check(inReady == (j == 7), "R8", inReady, (j == 7), {tag, " ready during drain"});
      for (int k = 0; k < 8; k++) begin
        int act = int'($signed(outCoef[k*16 +: 16]));
        check(act == expY[k][j], (k % 2 == 0) ? "R3 R6" : "R4 R6", act, expY[k][j],
              $sformatf("%s coef(%0d,%0d)", tag, k, j));
      end
      if (j == 7) inValid = 1'b0;
      @(negedge clk);
    end
    check(outValid == 1'b0, "R9", outValid, 0, {tag, " outValid ends after eight"});
  endtask

  task automatic testReset();
    check(outValid == 1'b0, "R1", outValid, 0, "reset outValid");
    check(inReady == 1'b1, "R1", inReady, 1, "reset inReady");
  endtask

  task automatic testZero();
    for (int i = 0; i < 8; i++) for (int n = 0; n < 8; n++) begin srcA[i][n] = 77; predA[i][n] = 77; end
    runBlock("R2 zero residual", 0, 0);
  endtask

  task automatic testNegativeFlat();
    for (int i = 0; i < 8; i++) for (int n = 0; n < 8; n++) begin srcA[i][n] = 0; predA[i][n] = 255; end
    runBlock("R5 negative flat", 0, 0);
  endtask

  task automatic testCheckerboard();
    for (int i = 0; i < 8; i++) for (int n = 0; n < 8; n++) begin
      srcA[i][n] = ((i + n) % 2 == 0) ? 255 : 0; predA[i][n] = 0;
    end
    runBlock("R4 checkerboard", 0, 0);
  endtask

  task automatic testRamp();
    for (int i = 0; i < 8; i++) for (int n = 0; n < 8; n++) begin
      srcA[i][n] = 30 * n + i; predA[i][n] = 100 - 3 * i;
    end
    runBlock("R6 ramp", 0, 0);
  endtask

  task automatic testRandomGaps();
    for (int i = 0; i < 8; i++) for (int n = 0; n < 8; n++) begin
      srcA[i][n] = nextRand(); predA[i][n] = nextRand();
    end
    runBlock("R7 random gaps", 1, 0);
  endtask

  task automatic testJunkDuringDrain();
    for (int i = 0; i < 8; i++) for (int n = 0; n < 8; n++) begin
      srcA[i][n] = nextRand(); predA[i][n] = nextRand();
    end
    runBlock("R10 junk drain", 0, 1);
    for (int i = 0; i < 8; i++) for (int n = 0; n < 8; n++) begin
      srcA[i][n] = (n < 4) ? 10 : 250; predA[i][n] = 3 * i + 5;
    end
    runBlock("R10 block after junk", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testZero();
    testNegativeFlat();
    testCheckerboard();
    testRamp();
    testRandomGaps();
    testJunkDuringDrain();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule